// File: doc/BRIEF.md
# Byte-Wide Static Memory with BCD Calendar Clock

The block is a byte-wide static memory whose eight highest addresses are a calendar clock rather than plain storage. A set of hidden counters keeps the time. Each pulse on a one-per-second tick input advances them. After each tick, control logic copies the counters into the eight clock bytes. The host reads and writes those bytes like any other location. All time fields are BCD: seconds, minutes, hours in 24-hour form, day of week, date, month and a two-digit year. Month lengths and leap years are handled automatically.

The lowest of the eight clock bytes is a control byte. It holds two halt bits and six bits of stored-only calibration data. The write halt bit lets the host set a new time: the host writes the clock bytes, then clears the bit, which loads those bytes into the counters. The read halt bit freezes the bytes so that a consistent snapshot can be read while the counters keep running. A power-fail input blocks every host write. The counters keep running while it is asserted.

The host port is sampled on a system clock. It has two chip enables of opposite polarity, an output enable, a write enable, and a data bus split into an input, an output and an output-drive flag.

Top module: `tk_calendar_sram`

## Requirements
- R1: With `ce1_n`=0, `ce2`=1, `oe_n`=0 and `we_n`=1, `dq_oe` is 1 and `dq_out` shows the byte at `addr`. In any other combination, `dq_oe` is 0 and `dq_out` is 0.
- R2: With `ce1_n`=0, `ce2`=1 and `we_n`=0 at a rising clock edge, `dq_in` is stored at `addr` whatever `oe_n` is, and it is read back unchanged.
- R3: While `pwr_fail` is 1, writes to the array, the clock bytes and the control byte are all ignored.
- R4: The top eight addresses, counted from 2^ADDR_W-8, are laid out as: offset 0 control, 1 seconds (bit 7 is the stop flag), 2 minutes, 3 hours (00-23), 4 day of week (1-7), 5 date, 6 month, 7 year (00-99), all in BCD. After reset the clock reads 00:00:00, day 1, date 01, month 01, year 00, and the control byte reads 00h.
- R5: Each tick adds one second in BCD. Seconds wrap from 59 to 00 and carry into minutes, and minutes wrap from 59 to 00 and carry into hours.
- R6: Hours wrap from 23 to 00. That wrap advances the day of week (7 goes to 1) and the date.
- R7: The last date is 30 for months 04, 06, 09 and 11, 31 for the other months except February, and for February 29 when the year is divisible by four (00 included) and 28 otherwise. Passing the last date gives date 01 of the next month.
- R8: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R9: While control bits 7 and 6 are both 0, the clock bytes 1-7 show the counters' new value from the second rising edge after a tick onward.
- R10: While control bit 7 is 1, the clock bytes are not refreshed and host writes to them stay. Writing the control byte with bit 7 = 0 while bit 7 is 1 loads bytes 1-7 into the counters.
- R11: While control bit 6 is 1, the clock bytes are frozen but the counters keep counting. Clearing bit 6 loads nothing, and the next tick shows the full elapsed time.
- R12: A seconds byte loaded with bit 7 = 1 stops the counters. The low six control bits are stored and read back, and they do not affect counting or refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| pwr_fail | input | 1 | Power-fail, blocks all writes |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Write data |
| dq_out | output | 8 | Read data, 0 when not driven |
| dq_oe | output | 1 | Data bus drive flag |

## Verification
The calendar is started from chosen instants that exercise each carry path in isolation:
- a BCD digit carry within minutes;
- a minute-to-hour carry;
- a full new-year rollover;
- the ends of February in a common year, in a leap year and in year 00;
- the end of a 30-day month and the end of a 31-day month.

A wrong month table or a wrong leap rule shows up as a date that differs from the expected one. The halt bits are checked against a running counter: one test freezes the bytes across several ticks and then confirms that the elapsed time appears, and another confirms that clearing the write bit loads the host's values. Enable combinations and power-fail writes are checked against both plain storage and the control byte.

// File: rtl/tk_pkg.sv
package tk_pkg;

  typedef struct packed {
    logic       stop;
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hr;
    logic [2:0] dow;
    logic [5:0] date;
    logic [4:0] mon;
    logic [7:0] yr;
  } tk_time_t;

  localparam tk_time_t RESET_TIME = '{stop: 1'b0, sec: 7'h00, min: 7'h00,
                                      hr: 6'h00, dow: 3'd1, date: 6'h01,
                                      mon: 5'h01, yr: 8'h00};

  localparam logic [2:0] IDX_CTL = 3'd0;

  // add one to a two-digit BCD value (no range wrap)
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic is_leap(input logic [7:0] y);
    logic [6:0] b;
    b = {3'b0, y[7:4]} * 7'd10 + {3'b0, y[3:0]};
    return b[1:0] == 2'b00;
  endfunction

  function automatic logic [5:0] last_date(input logic [4:0] m, input logic [7:0] y);
    case (m)
      5'h02:                      return is_leap(y) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

  function automatic logic [7:0] time_to_byte(input tk_time_t t, input logic [2:0] idx);
    case (idx)
      3'd1:    return {t.stop, t.sec};
      3'd2:    return {1'b0, t.min};
      3'd3:    return {2'b0, t.hr};
      3'd4:    return {5'b0, t.dow};
      3'd5:    return {2'b0, t.date};
      3'd6:    return {3'b0, t.mon};
      3'd7:    return t.yr;
      default: return 8'h00;
    endcase
  endfunction

  function automatic tk_time_t bytes_to_time(input logic [7:0][7:0] b);
    tk_time_t t;
    t.stop = b[1][7];
    t.sec  = b[1][6:0];
    t.min  = b[2][6:0];
    t.hr   = b[3][5:0];
    t.dow  = b[4][2:0];
    t.date = b[5][5:0];
    t.mon  = b[6][4:0];
    t.yr   = b[7];
    return t;
  endfunction

endpackage

// File: rtl/tk_host_decode.sv
module tk_host_decode #(
  parameter int ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              pwr_fail,
  output logic              rd_act,
  output logic              wr_ok,
  output logic              clk_sel,
  output logic [2:0]        clk_idx
);
  logic chip_on;
  logic wr_act;

  assign chip_on = !ce1_n && ce2;
  assign rd_act  = chip_on && !oe_n && we_n;
  assign wr_act  = chip_on && !we_n;
  assign wr_ok   = wr_act && !pwr_fail;
  assign clk_sel = &addr[ADDR_W-1:3];
  assign clk_idx = addr[2:0];
endmodule

// File: rtl/tk_sram.sv
module tk_sram #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/tk_counters.sv
module tk_counters
  import tk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     load,
  input  tk_time_t load_val,
  output tk_time_t cur,
  output logic     adv_ev,
  output logic     carry_day,
  output logic     carry_yr
);
  tk_time_t nxt;
  logic c_min, c_hr, c_mon;

  assign adv_ev = tick && !cur.stop;

  always_comb begin
    nxt       = cur;
    c_min     = cur.sec == 7'h59;
    c_hr      = c_min && (cur.min == 7'h59);
    carry_day = c_hr && (cur.hr == 6'h23);
    c_mon     = carry_day && (cur.date == last_date(cur.mon, cur.yr));
    carry_yr  = c_mon && (cur.mon == 5'h12);

    nxt.sec = c_min ? 7'h00 : 7'(bcd_inc({1'b0, cur.sec}));
    if (c_min) nxt.min = c_hr ? 7'h00 : 7'(bcd_inc({1'b0, cur.min}));
    if (c_hr)  nxt.hr  = carry_day ? 6'h00 : 6'(bcd_inc({2'b0, cur.hr}));
    if (carry_day) begin
      nxt.dow  = (cur.dow == 3'd7) ? 3'd1 : cur.dow + 3'd1;
      nxt.date = c_mon ? 6'h01 : 6'(bcd_inc({2'b0, cur.date}));
    end
    if (c_mon)    nxt.mon = carry_yr ? 5'h01 : 5'(bcd_inc({3'b0, cur.mon}));
    if (carry_yr) nxt.yr  = (cur.yr == 8'h99) ? 8'h00 : bcd_inc(cur.yr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cur <= RESET_TIME;
    else if (load)   cur <= load_val;
    else if (adv_ev) cur <= nxt;
  end
endmodule

// File: rtl/tk_clock_regs.sv
module tk_clock_regs
  import tk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] idx,
  input  logic [7:0] wdata,
  input  logic       tick,
  input  tk_time_t   cnt,
  output logic [7:0] rdata,
  output logic [7:0] ctl_q,
  output logic       load_ev,
  output logic       refresh_ev,
  output tk_time_t   load_val
);
  logic [7:0]      regs [8];
  logic [7:0][7:0] regs_flat;
  logic            tick_d;

  assign refresh_ev = tick_d && !(ctl_q[7] || ctl_q[6]);
  assign load_ev    = wr_en && (idx == IDX_CTL) && ctl_q[7] && !wdata[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_d <= 1'b0;
      regs[0] <= 8'h00;
    end else begin
      tick_d <= tick;
      if (wr_en && idx == IDX_CTL) regs[0] <= wdata;
    end
  end

  for (genvar i = 1; i < 8; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)                       regs[i] <= time_to_byte(RESET_TIME, 3'(i));
      else if (wr_en && idx == 3'(i))   regs[i] <= wdata;
      else if (refresh_ev)              regs[i] <= time_to_byte(cnt, 3'(i));
    end
  end

  always_comb begin
    for (int k = 0; k < 8; k++) regs_flat[k] = regs[k];
  end

  assign ctl_q    = regs[0];
  assign rdata    = regs[idx];
  assign load_val = bytes_to_time(regs_flat);
endmodule

// File: rtl/tk_calendar_sram.sv
module tk_calendar_sram
  import tk_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              pwr_fail,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_in,
  output logic [7:0]        dq_out,
  output logic              dq_oe
);
  logic       rd_act, wr_ok, clk_sel;
  logic [2:0] clk_idx;
  logic [7:0] sram_rd, clk_rd, ctl_q;
  logic       adv_ev, load_ev, refresh_ev, carry_day, carry_yr;
  tk_time_t   cnt, load_val;

  // named views for the checker
  logic [6:0] cnt_sec, load_sec;
  logic [5:0] cnt_hr;
  logic [4:0] cnt_mon;
  logic       cnt_stop;
  logic [7:0] byte_sec;

  tk_host_decode #(.ADDR_W(ADDR_W)) dec_i (
    .addr(addr), .ce1_n(ce1_n), .ce2(ce2), .oe_n(oe_n), .we_n(we_n),
    .pwr_fail(pwr_fail), .rd_act(rd_act), .wr_ok(wr_ok),
    .clk_sel(clk_sel), .clk_idx(clk_idx)
  );

  tk_sram #(.ADDR_W(ADDR_W), .DATA_W(8)) ram_i (
    .clk(clk), .we(wr_ok && !clk_sel), .addr(addr), .wdata(dq_in), .rdata(sram_rd)
  );

  tk_clock_regs regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ok && clk_sel), .idx(clk_idx),
    .wdata(dq_in), .tick(tick_1hz), .cnt(cnt), .rdata(clk_rd), .ctl_q(ctl_q),
    .load_ev(load_ev), .refresh_ev(refresh_ev), .load_val(load_val)
  );

  tk_counters cnt_i (
    .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .load(load_ev),
    .load_val(load_val), .cur(cnt), .adv_ev(adv_ev),
    .carry_day(carry_day), .carry_yr(carry_yr)
  );

  assign dq_oe  = rd_act;
  assign dq_out = rd_act ? (clk_sel ? clk_rd : sram_rd) : 8'h00;

  assign cnt_sec  = cnt.sec;
  assign cnt_hr   = cnt.hr;
  assign cnt_mon  = cnt.mon;
  assign cnt_stop = cnt.stop;
  assign load_sec = load_val.sec;
  assign byte_sec = {load_val.stop, load_val.sec};
endmodule

// File: rtl/tk_calendar_sram_chk.sv
module tk_calendar_sram_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       we_n,
  input logic       pwr_fail,
  input logic       dq_oe,
  input logic [7:0] ctl_q,
  input logic       wr_ok,
  input logic       clk_sel,
  input logic       adv_ev,
  input logic       load_ev,
  input logic       refresh_ev,
  input logic       carry_day,
  input logic       carry_yr,
  input logic [6:0] cnt_sec,
  input logic [5:0] cnt_hr,
  input logic [4:0] cnt_mon,
  input logic       cnt_stop,
  input logic [6:0] load_sec,
  input logic [7:0] byte_sec
);
  AST_NO_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !dq_oe);  // R1
  AST_PF_CTL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> $stable(ctl_q));  // R3
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    adv_ev && !load_ev && cnt_sec == 7'h59 |=> cnt_sec == 7'h00);  // R5
  AST_HOUR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    adv_ev && !load_ev && carry_day |=> cnt_hr == 6'h00);  // R6
  AST_MONTH_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    adv_ev && !load_ev && carry_yr |=> cnt_mon == 5'h01);  // R8
  AST_HALT_NO_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[7] || ctl_q[6]) && !(wr_ok && clk_sel) |=> $stable(byte_sec));  // R10
  AST_HALT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[7] || ctl_q[6]) |-> !refresh_ev);  // R9
  AST_LOAD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> cnt_sec == $past(load_sec));  // R10
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_stop && !load_ev |=> $stable(cnt_sec));  // R12
endmodule

bind tk_calendar_sram tk_calendar_sram_chk chk_i (
  .clk(clk), .rst_n(rst_n), .we_n(we_n), .pwr_fail(pwr_fail), .dq_oe(dq_oe),
  .ctl_q(ctl_q), .wr_ok(wr_ok), .clk_sel(clk_sel), .adv_ev(adv_ev),
  .load_ev(load_ev), .refresh_ev(refresh_ev), .carry_day(carry_day),
  .carry_yr(carry_yr), .cnt_sec(cnt_sec), .cnt_hr(cnt_hr), .cnt_mon(cnt_mon),
  .cnt_stop(cnt_stop), .load_sec(load_sec), .byte_sec(byte_sec)
);

// File: tb/tk_calendar_sram_tb_top.sv
module tk_calendar_sram_tb_top;
  localparam int AW = 11;
  localparam logic [AW-1:0] CB = AW'((1 << AW) - 8);

  logic clk = 1'b0, rst_n = 1'b0, tick_1hz = 1'b0, pwr_fail = 1'b0;
  logic ce1_n = 1'b1, ce2 = 1'b0, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] dq_in = '0, dq_out;
  logic dq_oe;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tk_calendar_sram #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .pwr_fail(pwr_fail),
    .ce1_n(ce1_n), .ce2(ce2), .oe_n(oe_n), .we_n(we_n), .addr(addr),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; dq_in = d; ce1_n = 1'b0; ce2 = 1'b1; we_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    ce1_n = 1'b1; ce2 = 1'b0; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; ce1_n = 1'b0; ce2 = 1'b1; we_n = 1'b1; oe_n = 1'b0;
    #1 d = dq_out;
    ce1_n = 1'b1; ce2 = 1'b0; oe_n = 1'b1;
  endtask

  task automatic expect_byte(input string req, input int off, input logic [7:0] exp);
    logic [7:0] d;
    rd(CB + AW'(off), d);
    check(req, d, exp);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic set_time(input logic [7:0] yr, mo, dt, dw, hr, mi, se);
    wr(CB, 8'h80);
    wr(CB + 1, se); wr(CB + 2, mi); wr(CB + 3, hr); wr(CB + 4, dw);
    wr(CB + 5, dt); wr(CB + 6, mo); wr(CB + 7, yr);
    wr(CB, 8'h00);
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    check("R1 idle no drive", {7'b0, dq_oe}, 8'h00);
    expect_byte("R4 reset ctl", 0, 8'h00);
    expect_byte("R4 reset sec", 1, 8'h00);
    expect_byte("R4 reset dow", 4, 8'h01);
    expect_byte("R4 reset date", 5, 8'h01);
    expect_byte("R4 reset month", 6, 8'h01);
    expect_byte("R4 reset year", 7, 8'h00);
  endtask

  task automatic t_rw;
    logic [7:0] d;
    wr(11'h005, 8'hA5); wr(11'h123, 8'h3C);
    rd(11'h005, d); check("R2 readback 005", d, 8'hA5);
    rd(11'h123, d); check("R2 readback 123", d, 8'h3C);
    @(negedge clk); addr = 11'h005; ce1_n = 1'b0; ce2 = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    #1 check("R1 oe_n high no drive", {dq_oe, dq_out[6:0]}, 8'h00);
    ce2 = 1'b0; oe_n = 1'b0;
    #1 check("R1 ce2 low no drive", {dq_oe, dq_out[6:0]}, 8'h00);
    ce2 = 1'b1; we_n = 1'b0; dq_in = 8'hA5;
    #1 check("R1 write no drive", {7'b0, dq_oe}, 8'h00);
    @(negedge clk); ce1_n = 1'b1; ce2 = 1'b0; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic t_pwr_fail;
    logic [7:0] d;
    pwr_fail = 1'b1;
    wr(11'h005, 8'h11); wr(CB, 8'h80); wr(CB + 2, 8'h42);
    pwr_fail = 1'b0;
    rd(11'h005, d); check("R3 array write blocked", d, 8'hA5);
    expect_byte("R3 ctl write blocked", 0, 8'h00);
    expect_byte("R3 clock write blocked", 2, 8'h00);
  endtask

  task automatic t_newyear;
    set_time(8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h58);
    expect_byte("R10 loaded sec visible", 1, 8'h58);
    tick(1);
    expect_byte("R9 refresh sec 59", 1, 8'h59);
    tick(1);
    expect_byte("R5 sec wrap", 1, 8'h00);
    expect_byte("R5 min wrap", 2, 8'h00);
    expect_byte("R6 hour wrap", 3, 8'h00);
    expect_byte("R6 dow 7 to 1", 4, 8'h01);
    expect_byte("R7 date to 01", 5, 8'h01);
    expect_byte("R8 month 12 to 01", 6, 8'h01);
    expect_byte("R8 year 99 to 00", 7, 8'h00);
  endtask

  task automatic t_carries;
    set_time(8'h24, 8'h05, 8'h10, 8'h03, 8'h10, 8'h09, 8'h59);
    tick(1);
    expect_byte("R5 minute BCD carry", 2, 8'h10);
    set_time(8'h24, 8'h05, 8'h10, 8'h03, 8'h10, 8'h59, 8'h59);
    tick(1);
    expect_byte("R5 hour carry", 3, 8'h11);
    expect_byte("R6 no day change", 5, 8'h10);
  endtask

  task automatic month_end(input string req, input logic [7:0] yr, mo, dt,
                           input logic [7:0] exp_mo, exp_dt);
    set_time(yr, mo, dt, 8'h02, 8'h23, 8'h59, 8'h59);
    tick(1);
    expect_byte(req, 5, exp_dt);
    expect_byte(req, 6, exp_mo);
  endtask

  task automatic t_months;
    month_end("R7 feb common", 8'h23, 8'h02, 8'h28, 8'h03, 8'h01);
    month_end("R7 feb leap 28", 8'h24, 8'h02, 8'h28, 8'h02, 8'h29);
    month_end("R7 feb leap 29", 8'h24, 8'h02, 8'h29, 8'h03, 8'h01);
    month_end("R7 feb year 00", 8'h00, 8'h02, 8'h28, 8'h02, 8'h29);
    month_end("R7 apr 30", 8'h24, 8'h04, 8'h30, 8'h05, 8'h01);
    month_end("R7 nov 30", 8'h24, 8'h11, 8'h30, 8'h12, 8'h01);
    month_end("R7 jan 30", 8'h24, 8'h01, 8'h30, 8'h01, 8'h31);
    month_end("R7 aug 31", 8'h24, 8'h08, 8'h31, 8'h09, 8'h01);
  endtask

  task automatic t_write_halt;
    set_time(8'h24, 8'h05, 8'h10, 8'h03, 8'h08, 8'h00, 8'h00);
    wr(CB, 8'h80); wr(CB + 1, 8'h30);
    tick(2);
    expect_byte("R10 held during halt", 1, 8'h30);
    wr(CB, 8'h00);
    tick(1);
    expect_byte("R10 load then count", 1, 8'h31);
  endtask

  task automatic t_read_halt;
    set_time(8'h24, 8'h05, 8'h10, 8'h03, 8'h08, 8'h00, 8'h10);
    wr(CB, 8'h40);
    tick(3);
    expect_byte("R11 snapshot frozen", 1, 8'h10);
    wr(CB, 8'h00);
    tick(1);
    expect_byte("R11 elapsed time kept", 1, 8'h14);
  endtask

  task automatic t_stop_cal;
    set_time(8'h24, 8'h05, 8'h10, 8'h03, 8'h08, 8'h00, 8'h85);
    tick(2);
    expect_byte("R12 stopped", 1, 8'h85);
    set_time(8'h24, 8'h05, 8'h10, 8'h03, 8'h08, 8'h00, 8'h05);
    wr(CB, 8'h2A);
    expect_byte("R12 cal bits stored", 0, 8'h2A);
    tick(1);
    expect_byte("R12 cal bits no effect", 1, 8'h06);
    wr(CB, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rw();
    t_pwr_fail();
    t_newyear();
    t_carries();
    t_months();
    t_write_halt();
    t_read_halt();
    t_stop_cal();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule